// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit processor core that completes every instruction in one clock. Each cycle it fetches the word addressed by its program counter from a private instruction store. It decodes the word, reads two operands from a 32-entry register file and runs them through an arithmetic unit. It then either writes a result back, stores a word to a private data store, or redirects the program counter. All of this settles combinationally between two rising edges.

The instruction and data stores are separate word-addressed arrays inside the block. Fetch and data access therefore never compete within a cycle. A test harness fills both arrays before releasing reset. The core exposes its fetch address, the current instruction, the register write port and the data store write port as outputs, so that its progress can be observed.

The supported operations are:
- register-register add, subtract, signed compare, AND and OR;
- word load and word store with a signed 16-bit displacement;
- a conditional branch that is taken when two registers are equal.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the program counter becomes 0 and every register reads as 0 afterwards.
- R2: The instruction executed each cycle is the instruction-store word at index `pc[..:2]`. For every instruction other than a taken branch, the next program counter is the current value plus 4.
- R3: Opcode 0x00 (bits 31:26) with funct (bits 5:0) of 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt respectively into register rd. The register fields are rs in bits 25:21, rt in bits 20:16 and rd in bits 15:11.
- R4: Opcode 0x00 with funct 0x2A writes 1 into rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 0x23 writes into register rt the data-store word at byte address rs plus the sign-extended bits 15:0.
- R6: Opcode 0x2B writes register rt into the data store at byte address rs plus the sign-extended bits 15:0. It writes no register.
- R7: For opcode 0x04, when rs equals rt the next program counter is PC+4 plus the sign-extended bits 15:0 shifted left by two. Otherwise it is PC+4. Nothing is written.
- R8: Register 0 always reads as zero. A write aimed at it has no effect.
- R9: Any other opcode, and opcode 0x00 with any other funct, writes nothing and only advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_o | output | 32 | Current program counter (byte address) |
| instr_o | output | 32 | Instruction fetched this cycle |
| rf_we_o | output | 1 | Register write enable for this cycle |
| rf_waddr_o | output | 5 | Register number being written |
| rf_wdata_o | output | 32 | Value being written to the register file |
| dm_we_o | output | 1 | Data store write enable for this cycle |
| dm_addr_o | output | 32 | Data store byte address (ALU result) |
| dm_wdata_o | output | 32 | Data being stored |

## Verification
A corrupted register shows up on the write port at the first later instruction that reads it, usually within a few cycles. A corrupted data word shows up at the next load of that address. A wrong next-PC computation appears on `pc_o` one clock later, and every following fetch is then out of step. The bench runs a behavioural instruction-level model next to the core and compares the program counter and both write ports on every cycle. Any divergence is therefore reported in the cycle where it first becomes visible.

// File: rtl/sc_pkg.sv
// Shared encodings and control types for the single-cycle core.
// Assumes the fixed 32-bit instruction layout used throughout the core.
package sc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BREQ  = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_fn_e;

    typedef enum logic [1:0] {
        AC_ADD,
        AC_SUB,
        AC_FUNCT,
        AC_NONE
    } alu_class_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    src_imm;
        logic    mem_write;
        logic    wb_from_mem;
        logic    branch;
        alu_fn_e alu_fn;
    } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
// Main decoder plus ALU-control decoder.
// The main stage classifies the opcode; the second stage resolves the
// funct field for register-register operations. Unknown opcodes and
// unknown functs yield an all-inactive control word (a no-op).
module sc_decoder
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    alu_class_e alu_class;
    ctrl_t      base;
    alu_fn_e    fn_sel;
    logic       fn_valid;

    // Main decode: datapath steering per opcode.
    always_comb begin
        base      = '0;
        base.alu_fn = ALU_ADD;
        alu_class = AC_NONE;
        unique case (opcode)
            OP_RTYPE: begin
                base.reg_write = 1'b1;
                base.dst_is_rd = 1'b1;
                alu_class      = AC_FUNCT;
            end
            OP_LOAD: begin
                base.reg_write   = 1'b1;
                base.src_imm     = 1'b1;
                base.wb_from_mem = 1'b1;
                alu_class        = AC_ADD;
            end
            OP_STORE: begin
                base.src_imm   = 1'b1;
                base.mem_write = 1'b1;
                alu_class      = AC_ADD;
            end
            OP_BREQ: begin
                base.branch = 1'b1;
                alu_class   = AC_SUB;
            end
            default: alu_class = AC_NONE;
        endcase
    end

    // ALU control: pick the ALU function from class and funct.
    always_comb begin
        fn_sel   = ALU_ADD;
        fn_valid = 1'b1;
        unique case (alu_class)
            AC_ADD:  fn_sel = ALU_ADD;
            AC_SUB:  fn_sel = ALU_SUB;
            AC_FUNCT: begin
                unique case (funct)
                    FN_ADD:  fn_sel = ALU_ADD;
                    FN_SUB:  fn_sel = ALU_SUB;
                    FN_AND:  fn_sel = ALU_AND;
                    FN_OR:   fn_sel = ALU_OR;
                    FN_SLT:  fn_sel = ALU_SLT;
                    default: fn_valid = 1'b0;
                endcase
            end
            default: fn_sel = ALU_ADD;
        endcase
    end

    // Merge: an unrecognised funct cancels the register write.
    always_comb begin
        ctrl           = base;
        ctrl.alu_fn    = fn_sel;
        ctrl.reg_write = base.reg_write & fn_valid;
    end

endmodule

// File: rtl/sc_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 is a constant zero; the others reset to zero synchronously
// (active-low) and load on the rising edge when written.
module sc_regfile #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata
);

    logic [NREG-1:0][WIDTH-1:0] regs;

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        if (g == 0) begin : g_zero
            assign regs[g] = '0;
        end else begin : g_store
            logic [WIDTH-1:0] q;
            // Hold one architectural register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (we && waddr == AW'(g))
                    q <= wdata;
            end
            assign regs[g] = q;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/sc_alu.sv
// Integer ALU: add, subtract, signed set-less-than, AND, OR.
// The zero flag reports an all-zero result and drives branch resolution.
module sc_alu
    import sc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_fn_e          fn,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    // Select the operation result.
    always_comb begin
        unique case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = WIDTH'($signed(a) < $signed(b));
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_ram.sv
// Word-wide array with a combinational read and a write on the rising
// edge. No reset: contents are loaded by the environment before use.
module sc_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store one word when enabled.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: program counter, fetch, decode, register file,
// ALU, data store and next-PC selection. Every instruction retires on the
// rising edge that ends its cycle. Stores are word-addressed: the low two
// address bits are ignored and addresses wrap within each store.
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int XLEN      = 32,
    localparam int NREG      = 32,
    localparam int RAW       = $clog2(NREG),
    localparam int IAW       = $clog2(IMEM_WORDS),
    localparam int DAW       = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] instr_o,
    output logic            rf_we_o,
    output logic [RAW-1:0]  rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o,
    output logic            dm_we_o,
    output logic [XLEN-1:0] dm_addr_o,
    output logic [XLEN-1:0] dm_wdata_o
);

    logic [XLEN-1:0] pc, pc_next, pc_plus4, br_target;
    logic [XLEN-1:0] instr, imm_ext;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
    logic [RAW-1:0]  waddr;
    logic            alu_zero, br_taken;
    ctrl_t           ctrl;

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else
            pc <= pc_next;
    end

    sc_ram #(.DEPTH(IMEM_WORDS), .WIDTH(XLEN)) u_imem (
        .clk   (clk),
        .we    (1'b0),
        .addr  (pc[IAW+1:2]),
        .wdata ('0),
        .rdata (instr)
    );

    sc_decoder u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign waddr   = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];

    sc_regfile #(.NREG(NREG), .WIDTH(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (instr[25:21]),
        .raddr_b (instr[20:16]),
        .rdata_a (rs_val),
        .rdata_b (rt_val),
        .we      (ctrl.reg_write),
        .waddr   (waddr),
        .wdata   (wb_data)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

    sc_alu #(.WIDTH(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (ctrl.alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    sc_ram #(.DEPTH(DMEM_WORDS), .WIDTH(XLEN)) u_dmem (
        .clk   (clk),
        .we    (ctrl.mem_write),
        .addr  (alu_y[DAW+1:2]),
        .wdata (rt_val),
        .rdata (dm_rdata)
    );

    assign wb_data = ctrl.wb_from_mem ? dm_rdata : alu_y;

    // Next-PC selection: sequential or branch target.
    always_comb begin
        pc_plus4  = pc + XLEN'(4);
        br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
        br_taken  = ctrl.branch & alu_zero;
        pc_next   = br_taken ? br_target : pc_plus4;
    end

    assign pc_o       = pc;
    assign instr_o    = instr;
    assign rf_we_o    = ctrl.reg_write;
    assign rf_waddr_o = waddr;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = ctrl.mem_write;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

endmodule

// File: rtl/sc_core_chk.sv
// Property checker for sc_core, attached by bind. Observes the PC,
// branch resolution, register read/write ports and store enable.
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        br_taken,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        rf_we,
    input logic [31:0] rf_wdata,
    input logic        dm_we
);

    logic prev_rst_low = 1'b0;

    // Remember whether reset was sampled on the previous edge.
    always_ff @(posedge clk) prev_rst_low <= !rst_n;

    // R1: first cycle after reset starts at address 0
    assert_reset_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        prev_rst_low |-> pc == 32'd0);

    // R2: sequential advance when no branch is taken
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |=> pc == $past(pc) + 32'd4);

    // R7: a taken branch only when the compared registers match
    assert_beq_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> rs_val == rt_val);

    // R6: a store never writes the register file
    assert_store_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> !rf_we);

    // R8: reading register 0 yields zero
    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        instr[25:21] == 5'd0 |-> rs_val == 32'd0);

    // R4: compare result is 0 or 1
    assert_slt_bool_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && instr[31:26] == 6'h00 && instr[5:0] == 6'h2A)
            |-> rf_wdata[31:1] == 31'd0);

endmodule

bind sc_core sc_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc),
    .instr    (instr),
    .br_taken (br_taken),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .rf_we    (rf_we_o),
    .rf_wdata (rf_wdata_o),
    .dm_we    (dm_we_o)
);

// File: tb/tb_sc_core.sv
// Bench: runs a program on sc_core next to a behavioural instruction-level
// model and compares PC and both write ports every cycle.
module tb_sc_core;

    localparam int IW = 64;
    localparam int DW = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] prog [IW];
    logic [31:0] rdm  [DW];
    logic [31:0] rreg [32];
    logic [31:0] rpc;

    always #4 clk = ~clk;

    sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_o       (pc_o),
        .instr_o    (instr_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    // Compare current cycle against the model, then retire in the model.
    task automatic step();
        logic [31:0] ins, a, b, sx, ea, wd, npc;
        logic [5:0]  op, fn;
        int          rs, rt, rd, wa;
        logic        ewe, edwe;
        string       tag;
        ins = prog[rpc[7:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a = rreg[rs]; b = rreg[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        ea = a + sx;
        ewe = 1'b0; edwe = 1'b0; wa = 0; wd = '0;
        npc = rpc + 32'd4; tag = "R9";
        case (op)
            6'h00: begin
                ewe = 1'b1; wa = rd; tag = "R3";
                case (fn)
                    6'h20: wd = a + b;
                    6'h22: wd = a - b;
                    6'h24: wd = a & b;
                    6'h25: wd = a | b;
                    6'h2A: begin wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
                    default: begin ewe = 1'b0; tag = "R9"; end
                endcase
                if (ewe && rs == 0 && rt == 0) tag = "R8";
            end
            6'h23: begin ewe = 1'b1; wa = rt; wd = rdm[ea[7:2]]; tag = "R5"; end
            6'h2B: begin edwe = 1'b1; tag = "R6"; end
            6'h04: begin
                tag = "R7";
                if (a == b) npc = rpc + 32'd4 + {sx[29:0], 2'b00};
            end
            default: tag = "R9";
        endcase
        chk(rpc[7:2] == 6'd0 ? "R2" : tag, "pc", pc_o, rpc);
        chk(tag, "rf_we", {31'd0, rf_we_o}, {31'd0, ewe});
        if (ewe) begin
            chk(tag, "rf_waddr", {27'd0, rf_waddr_o}, 32'(wa));
            chk(tag, "rf_wdata", rf_wdata_o, wd);
        end
        chk(tag, "dm_we", {31'd0, dm_we_o}, {31'd0, edwe});
        if (edwe) begin
            chk(tag, "dm_addr", dm_addr_o, ea);
            chk(tag, "dm_wdata", dm_wdata_o, b);
        end
        if (ewe && wa != 0) rreg[wa] = wd;
        if (edwe) rdm[ea[7:2]] = b;
        rpc = npc;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 5000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Main sequence.
    initial begin
        for (int i = 0; i < IW; i++) prog[i] = 32'hFC00_0000;
        for (int i = 0; i < DW; i++) rdm[i] = 32'(i * 7 + 100);
        rdm[0] = 32'd5; rdm[1] = 32'hFFFF_FFFD; rdm[2] = 32'h7FFF_FFFF; rdm[3] = 32'h1234_5678;
        prog[0]  = enc_i(6'h23, 0, 1, 0);
        prog[1]  = enc_i(6'h23, 0, 2, 4);
        prog[2]  = enc_i(6'h23, 0, 3, 12);
        prog[3]  = enc_r(1, 2, 4, 6'h20);
        prog[4]  = enc_r(1, 2, 5, 6'h22);
        prog[5]  = enc_r(3, 2, 6, 6'h24);
        prog[6]  = enc_r(1, 3, 7, 6'h25);
        prog[7]  = enc_r(2, 1, 8, 6'h2A);
        prog[8]  = enc_r(1, 2, 9, 6'h2A);
        prog[9]  = enc_r(1, 1, 0, 6'h20);
        prog[10] = enc_r(0, 0, 10, 6'h20);
        prog[11] = enc_i(6'h2B, 0, 4, 16);
        prog[12] = enc_i(6'h23, 0, 11, 16);
        prog[13] = enc_i(6'h04, 4, 11, 2);
        prog[14] = enc_r(1, 1, 12, 6'h20);
        prog[15] = enc_r(1, 1, 12, 6'h20);
        prog[16] = enc_i(6'h04, 1, 2, 5);
        prog[17] = 32'hFC00_0000;
        prog[18] = enc_r(1, 2, 15, 6'h00);
        prog[19] = enc_r(4, 4, 13, 6'h20);
        prog[20] = enc_i(6'h2B, 13, 5, -4);
        prog[21] = enc_i(6'h23, 13, 14, -4);
        prog[22] = enc_i(6'h04, 0, 0, -1);
        for (int i = 0; i < IW; i++) dut.u_imem.mem[i] = prog[i];
        for (int i = 0; i < DW; i++) dut.u_dmem.mem[i] = rdm[i];
        for (int i = 0; i < 32; i++) rreg[i] = '0;
        rpc = '0;

        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "pc after reset", pc_o, 32'd0);
        rst_n = 1'b1;
        step();
        for (int c = 0; c < 59; c++) begin
            @(negedge clk);
            step();
        end

        // Reset in mid-run: PC and registers clear, data store keeps contents.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "pc after mid-run reset", pc_o, 32'd0);
        for (int i = 0; i < 32; i++) rreg[i] = '0;
        rpc = '0;
        rst_n = 1'b1;
        step();
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule